// File: doc/BRIEF.md
# Three-Phase Oversampled Tracking Data Recovery

This block is the digital half of a receiver for a mesochronous serial link. Every bit interval it takes three samples of the incoming line, captured at an early, a centre and a late clock phase. From where the bit edges fall among those three samples it decides whether the sampling phases run ahead of or behind the bit boundaries. It then sends single step commands to an external phase shifter so that all three samples come back inside one bit. The centre sample is always the recovered bit; no data-selection logic chooses among the phases.

The recovered bits are packed into a four-lane word at one quarter of the bit rate, with one clock per bit. Phase corrections are rate-limited: votes are gathered over a fixed window of reference cycles, and at most one step is issued per window. The line cannot be stalled. The sample input is qualified by `in_valid` alone, and the word output is a one-cycle `word_valid` strobe with no ready. The consumer must take each word in the cycle it is flagged, and the word register holds its value until the next word completes.

Top module: `drc_tracking_top`

## Requirements
- R1: The recovered bit is always `samp_mid`. Bits fill `word_data` in arrival order: the first accepted bit after reset or after the previous word goes to bit 0 (lane 0) and the fourth to bit 3.
- R2: `word_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the fourth bit of a word. `word_data` changes only in that cycle and holds its value otherwise.
- R3: When `in_valid` is low, the three samples are ignored: they produce no vote and no recovered bit.
- R4: An accepted sample gives an early vote when `samp_early` differs from `samp_mid` while `samp_late` equals it. It gives a late vote in the mirror case. When all three samples agree, or when both outer samples differ from the centre, it gives no vote.
- R5: Windows are 8 clock cycles long and are counted on every cycle from the release of reset, whatever `in_valid` does. Within a window, early votes count +1 and late votes count −1. If the net count at the end of a window is +2 or more, `step_later` pulses in the following cycle. If it is −2 or less, `step_earlier` pulses in that cycle instead. Otherwise neither pulses.
- R6: The vote count is cleared after every window decision, so votes never carry into the next window.
- R7: `step_later` and `step_earlier` are never high together, each pulse lasts one cycle, and two step pulses are at least 8 cycles apart.
- R8: A synchronous active-low reset clears the vote count, the window position and the lane index, and drives all outputs low. After reset, `word_valid` stays low until four new bits have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, also the reference for the step window |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the three samples for this bit |
| samp_early | input | 1 | Line sample at the early phase |
| samp_mid | input | 1 | Line sample at the centre phase |
| samp_late | input | 1 | Line sample at the late phase |
| word_valid | output | 1 | One-cycle strobe: `word_data` holds a new word |
| word_data | output | 4 | Recovered word, bit 0 received first |
| step_later | output | 1 | One-cycle command to move the sampling phases later |
| step_earlier | output | 1 | One-cycle command to move the sampling phases earlier |

## Verification
With a continuous stream, a window of 8 cycles closes exactly when a second word completes, so a step pulse and a word strobe land in the same cycle. The bench forces this on purpose. It feeds windows whose votes cross the threshold while the centre samples spell known words, and it checks the step and the word independently in that shared cycle. A long run with a phase that slowly drifts earlier keeps this coincidence recurring. In that run the bench applies every step the block issues to its own phase model, and it requires both that the phase error stays within one position and that every word matches the bits sent.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE  = 2'b00,
    VOTE_EARLY = 2'b01,
    VOTE_LATE  = 2'b10
  } vote_e;

  // Edge position among three samples of one bit.
  function automatic vote_e classify(input logic e, input logic m, input logic l);
    if ((e != m) && (l == m))      return VOTE_EARLY;
    else if ((l != m) && (e == m)) return VOTE_LATE;
    else                           return VOTE_NONE;
  endfunction

endpackage

// File: rtl/drc_phase_detect.sv
module drc_phase_detect
  import drc_pkg::*;
(
  input  logic  in_valid,
  input  logic  samp_early,
  input  logic  samp_mid,
  input  logic  samp_late,
  output vote_e vote,
  output logic  bit_valid,
  output logic  bit_data
);

  always_comb begin
    bit_valid = in_valid;
    bit_data  = samp_mid;
    vote      = in_valid ? classify(samp_early, samp_mid, samp_late) : VOTE_NONE;
  end

endmodule

// File: rtl/drc_loop_filter.sv
module drc_loop_filter
  import drc_pkg::*;
#(
  parameter int WINDOW = 8,
  parameter int THRESH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  vote_e vote,
  output logic  step_later,
  output logic  step_earlier
);

  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int ACC_W = $clog2(WINDOW + 1) + 1;
  localparam logic signed [ACC_W-1:0] POS_T = ACC_W'(THRESH);
  localparam logic signed [ACC_W-1:0] NEG_T = -POS_T;
  localparam logic [WIN_W-1:0] LAST_POS = WIN_W'(WINDOW - 1);

  logic [WIN_W-1:0]        win_pos;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] delta;
  logic signed [ACC_W-1:0] acc_next;
  logic                    window_end;

  always_comb begin
    unique case (vote)
      VOTE_EARLY: delta = ACC_W'(1);
      VOTE_LATE:  delta = -ACC_W'(1);
      default:    delta = '0;
    endcase
    acc_next   = acc_q + delta;
    window_end = (win_pos == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_pos      <= '0;
      acc_q        <= '0;
      step_later   <= 1'b0;
      step_earlier <= 1'b0;
    end else begin
      step_later   <= window_end && (acc_next >= POS_T);
      step_earlier <= window_end && (acc_next <= NEG_T);
      if (window_end) begin
        win_pos <= '0;
        acc_q   <= '0;
      end else begin
        win_pos <= win_pos + WIN_W'(1);
        acc_q   <= acc_next;
      end
    end
  end

endmodule

// File: rtl/drc_deser.sv
module drc_deser #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             word_valid,
  output logic [LANES-1:0] word_data
);

  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] lane_q;
  logic [LANES-1:0] full_word;
  logic             last_bit;

  assign last_bit = bit_valid && (idx == LAST_IDX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q[g] <= 1'b0;
      else if (bit_valid && (idx == IDX_W'(g)))
        lane_q[g] <= bit_data;
    end
    assign full_word[g] = (idx == IDX_W'(g)) ? bit_data : lane_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= last_bit;
      if (last_bit) begin
        word_data <= full_word;
        idx       <= '0;
      end else if (bit_valid) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/drc_tracking_top.sv
module drc_tracking_top
  import drc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WINDOW = 8,
  parameter int THRESH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             samp_early,
  input  logic             samp_mid,
  input  logic             samp_late,
  output logic             word_valid,
  output logic [LANES-1:0] word_data,
  output logic             step_later,
  output logic             step_earlier
);

  vote_e vote;
  logic  bit_valid;
  logic  bit_data;

  drc_phase_detect u_pd (
    .in_valid   (in_valid),
    .samp_early (samp_early),
    .samp_mid   (samp_mid),
    .samp_late  (samp_late),
    .vote       (vote),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data)
  );

  drc_loop_filter #(.WINDOW(WINDOW), .THRESH(THRESH)) u_lf (
    .clk          (clk),
    .rst_n        (rst_n),
    .vote         (vote),
    .step_later   (step_later),
    .step_earlier (step_earlier)
  );

  drc_deser #(.LANES(LANES)) u_des (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
  parameter int LANES  = 4,
  parameter int WINDOW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             word_valid,
  input logic [LANES-1:0] word_data,
  input logic             step_later,
  input logic             step_earlier
);

  localparam int GAP_W = $clog2(WINDOW + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(WINDOW);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(WINDOW - 1);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)
      gap <= GAP_MAX;
    else if (step_later || step_earlier)
      gap <= '0;
    else if (gap != GAP_MAX)
      gap <= gap + GAP_W'(1);
  end

  AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_later && step_earlier)); // R7
  AST_LATER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_later |=> !step_later); // R7
  AST_EARLIER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_earlier |=> !step_earlier); // R7
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step_later || step_earlier) |-> (gap >= GAP_MIN)); // R7
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data)); // R2
  AST_WORD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(in_valid)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!word_valid && !step_later && !step_earlier)); // R8

endmodule

bind drc_tracking_top drc_checker #(.LANES(LANES), .WINDOW(WINDOW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .word_valid   (word_valid),
  .word_data    (word_data),
  .step_later   (step_later),
  .step_earlier (step_earlier)
);

// File: tb/tb_drc_tracking_top.sv
module tb_drc_tracking_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       samp_early = 1'b0, samp_mid = 1'b0, samp_late = 1'b0;
  logic       word_valid;
  logic [3:0] word_data;
  logic       step_later, step_earlier;

  int checks = 0;
  int errors = 0;
  int both_cnt = 0;

  logic       got_valid, got_later, got_earlier;
  logic [3:0] got_word;

  always #4 clk = ~clk;

  drc_tracking_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .samp_early(samp_early), .samp_mid(samp_mid), .samp_late(samp_late),
    .word_valid(word_valid), .word_data(word_data),
    .step_later(step_later), .step_earlier(step_earlier)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; captures outputs just after the rising edge.
  task automatic step_in(input logic e, input logic m, input logic l, input logic v);
    samp_early = e; samp_mid = m; samp_late = l; in_valid = v;
    @(posedge clk);
    #1;
    got_valid = word_valid; got_word = word_data;
    got_later = step_later; got_earlier = step_earlier;
    if (got_later && got_earlier) both_cnt++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One full window: ne early votes, nl late votes, nc conflicting, rest clean.
  task automatic vote_window(input int ne, input int nl, input int nc,
                             input int exp_later, input int exp_earlier, input string req);
    int early_seen = 0;
    for (int k = 0; k < 8; k++) begin
      logic b = k[0];
      if (k < ne)                step_in(~b, b, b, 1'b1);
      else if (k < ne + nl)      step_in(b, b, ~b, 1'b1);
      else if (k < ne + nl + nc) step_in(~b, b, ~b, 1'b1);
      else                       step_in(b, b, b, 1'b1);
      if (k < 7 && (got_later || got_earlier)) early_seen++;
    end
    check_eq(req, "step inside window", early_seen, 0);
    check_eq(req, "step_later at window end", int'(got_later), exp_later);
    check_eq(req, "step_earlier at window end", int'(got_earlier), exp_earlier);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check_eq("R8", "word_valid in reset", int'(word_valid), 0);
    check_eq("R8", "word_data in reset", int'(word_data), 0);
    check_eq("R8", "steps in reset", int'(step_later | step_earlier), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step_in(1'b1, 1'b1, 1'b1, 1'b1);
      check_eq("R8", "no word before four bits", int'(got_valid), 0);
    end
  endtask

  task automatic t_lane_order();
    logic [7:0] bits = 8'b1011_0001; // bit k sent k-th
    do_reset();
    for (int k = 0; k < 8; k++) begin
      step_in(bits[k], bits[k], bits[k], 1'b1);
      if (k == 3) begin
        check_eq("R1", "first word lane order", int'(got_word), 4'b0001);
        check_eq("R2", "strobe after fourth bit", int'(got_valid), 1);
      end else if (k == 4) begin
        check_eq("R2", "strobe lasts one cycle", int'(got_valid), 0);
        check_eq("R2", "word held", int'(got_word), 4'b0001);
      end
    end
    check_eq("R1", "second word lane order", int'(got_word), 4'b1011);
    check_eq("R5", "clean window gives no step", int'(got_later | got_earlier), 0);
  endtask

  task automatic t_ignore();
    logic [7:0] bits = 8'b0010_1101;
    int nvalid = 0, nstep = 0;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      if (k[0] == 1'b0) step_in(bits[k/2], bits[k/2], bits[k/2], 1'b1);
      else              step_in(1'b1, 1'b0, 1'b0, 1'b0); // would be an early vote
      if (got_valid) nvalid++;
      if (got_later || got_earlier) nstep++;
      if (k == 6)  check_eq("R3", "word skips idle cycles", int'(got_word), 4'b1101);
      if (k == 14) check_eq("R3", "second word skips idle cycles", int'(got_word), 4'b0010);
    end
    check_eq("R3", "words from valid bits only", nvalid, 2);
    check_eq("R3", "idle samples cast no vote", nstep, 0);
  endtask

  task automatic t_votes();
    do_reset();
    vote_window(3, 0, 0, 1, 0, "R4");
    step_in(1'b0, 1'b0, 1'b0, 1'b1); // window restarts
    check_eq("R7", "step_later one cycle", int'(got_later), 0);
    for (int k = 0; k < 7; k++) step_in(1'b0, 1'b0, 1'b0, 1'b1);
    vote_window(0, 3, 0, 0, 1, "R4");
    vote_window(2, 1, 0, 0, 0, "R5");   // net +1
    vote_window(2, 0, 0, 1, 0, "R5");   // net +2 boundary
    vote_window(0, 2, 0, 0, 1, "R5");   // net -2 boundary
    vote_window(0, 0, 4, 0, 0, "R4");   // conflicts only
    vote_window(2, 0, 6, 1, 0, "R4");   // conflicts do not cancel
  endtask

  task automatic t_clear();
    do_reset();
    vote_window(1, 0, 0, 0, 0, "R6");
    vote_window(1, 0, 0, 0, 0, "R6");   // would reach +2 if carried
    vote_window(5, 0, 0, 1, 0, "R6");
    vote_window(0, 0, 0, 0, 0, "R6");   // excess +5 discarded
    vote_window(0, 1, 0, 0, 0, "R6");
    vote_window(0, 1, 0, 0, 0, "R6");
  endtask

  // Phase drifts earlier; bench applies each step to its phase model.
  task automatic t_drift();
    logic [7:0] lf = 8'hA5;
    logic prev = 1'b0;
    logic [3:0] sent = '0;
    int phi = 0, max_err = 0, nlater = 0, nearlier = 0, ndrift = 0;
    int bad_words = 0, nwords = 0;
    do_reset();
    for (int c = 0; c < 480; c++) begin
      logic b = lf[0];
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      sent[c % 4] = b;
      step_in((phi < 0) ? prev : b, b, b, 1'b1);
      prev = b;
      if (got_later) begin nlater++; phi++; end
      if (got_earlier) begin nearlier++; phi--; end
      if (c % 4 == 3) begin
        nwords++;
        if (!got_valid || got_word != sent) bad_words++;
      end
      if (c % 48 == 20) begin phi--; ndrift++; end
      if (-phi > max_err) max_err = -phi;
      if (phi > max_err) max_err = phi;
    end
    check_eq("R5", "later steps track drift", nlater, ndrift);
    check_eq("R5", "no opposite steps", nearlier, 0);
    check_eq("R5", "final phase error", phi, 0);
    check_eq("R5", "phase error bound", max_err, 1);
    check_eq("R1", "words during drift", nwords, 120);
    check_eq("R1", "mismatched words during drift", bad_words, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_lane_order();
    t_ignore();
    t_votes();
    t_clear();
    t_drift();
    check_eq("R7", "cycles with both steps", both_cnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule